// File: doc/BRIEF.md
# CAN Error Flag, Error Code and Error Level Logic

This block is the error-reporting register set of a CAN controller. It takes single-cycle event pulses from the protocol engine, together with the live transmit and receive error counts, and turns them into three things the CPU can see. The first is a byte of sticky error flags with a matching enable byte. The second is a byte of protocol error codes that either accumulates or keeps only the newest error. The third is a two-bit error level that classifies the counters. One combined error interrupt is raised from the enabled flags.

The CPU reaches the block through byte-wide registers at eight addresses. Flags and error codes are cleared by writing 0 to the bit concerned. A written 1 leaves that bit alone, so software can clear exactly the bits it has handled without a read-modify-write race. Bit errors on the bus are detected by the protocol engine, not here.

Top module: `can_err_regs`

## Requirements
- R1: Each event input sets its flag bit at the next clock edge. The flag register (address 0) uses bit 7 for bus lock, bit 6 for overload frame sent, bit 5 for receive overrun, bit 4 for bus-off recovery, bit 3 for bus-off entry, bit 2 for error passive, bit 1 for error warning and bit 0 for bus error. The bus error flag sets on any nonzero error code event.
- R2: A write to address 0 clears each flag whose written bit is 0 and leaves each flag whose written bit is 1 unchanged.
- R3: When an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R4: Error code register (address 2) bits 6..0 are ACK delimiter error, bit error dominant, bit error recessive, CRC error, ACK error, form error and stuff error. The error code event input uses the same bit order. A write clears each code bit written 0 and keeps each bit written 1.
- R5: With error code bit 7 (mode, written directly) at 1, new error codes are ORed into the stored codes.
- R6: With mode at 0, a new nonzero error code event replaces bits 6..0 with the new codes.
- R7: The warning flag sets in the cycle after the larger of the two counts first reaches 96. It does not set again while that count stays at or above 96.
- R8: The passive flag sets in the cycle after either count first exceeds 127.
- R9: The bus-off entry flag sets in the cycle after the transmit count first exceeds 255.
- R10: `err_level` (also readable at address 7, bits 1..0) is a registered classification of the counts: 0 active, 1 warning, 2 passive, 3 bus-off. It is 0 after reset, as are all flags, enables and codes.
- R11: Status register (address 5) bit 5 is 1 while any flag is set whose enable bit (address 1, same bit positions) is 1. `err_irq` is that bit ANDed with bit 5 of the interrupt enable register (address 6).
- R12: Addresses 3 and 4 read the transmit and receive counts as 8-bit values, saturated at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on address) |
| ev_bus_lock | input | 1 | Bus lock event pulse |
| ev_overload | input | 1 | Overload frame sent pulse |
| ev_overrun | input | 1 | Receive overrun pulse |
| ev_bo_recover | input | 1 | Bus-off recovery pulse |
| err_code_ev | input | 7 | Protocol error type pulses, same order as code bits 6..0 |
| tx_err_cnt | input | 9 | Transmit error count |
| rx_err_cnt | input | 9 | Receive error count |
| err_level | output | 2 | Error level: 0 active, 1 warning, 2 passive, 3 bus-off |
| err_irq | output | 1 | Combined error interrupt |

## Verification
The bench builds the block with its default parameters: a 9-bit count width and thresholds of 96, 127 and 255. These defaults let the transmit count step past 255, so the bench can reach bus-off entry and the saturated counter read. The bench also steps the counts through every threshold in turn and raises the receive count over two thresholds in one cycle, which checks that the warning and passive flags can set together.

// File: rtl/can_err_pkg.sv
package can_err_pkg;

  typedef enum logic [1:0] {
    LVL_ACTIVE  = 2'd0,
    LVL_WARN    = 2'd1,
    LVL_PASSIVE = 2'd2,
    LVL_BUSOFF  = 2'd3
  } err_level_e;

  localparam int FLAG_W = 8;
  localparam int CODE_W = 7;

  // Register addresses
  localparam logic [2:0] A_FLAG = 3'd0;
  localparam logic [2:0] A_FEN  = 3'd1;
  localparam logic [2:0] A_CODE = 3'd2;
  localparam logic [2:0] A_TXC  = 3'd3;
  localparam logic [2:0] A_RXC  = 3'd4;
  localparam logic [2:0] A_STAT = 3'd5;
  localparam logic [2:0] A_IEN  = 3'd6;
  localparam logic [2:0] A_LVL  = 3'd7;

  // Flag bit positions
  localparam int FB_BUSERR   = 0;
  localparam int FB_WARN     = 1;
  localparam int FB_PASSIVE  = 2;
  localparam int FB_BOENTRY  = 3;
  localparam int FB_BORECOV  = 4;
  localparam int FB_OVERRUN  = 5;
  localparam int FB_OVERLOAD = 6;
  localparam int FB_BUSLOCK  = 7;

  // Combined interrupt bit in status and interrupt enable registers
  localparam int IRQ_BIT = 5;

endpackage

// File: rtl/can_err_flagbank.sv
module can_err_flagbank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_q;
  logic [W-1:0] q_d;
  logic         upd;

  // Per-bit next state: a hardware set overrides a clearing write.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign q_d[i] = set_i[i] | (q_q[i] & ~(wr_i & ~wdata_i[i]));
  end

  assign upd = wr_i | (|set_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
    end else if (upd) begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;

  p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((q_q & $past(set_i)) == $past(set_i)));

  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && ((set_i & ~wdata_i) != '0)) |=> ((q_q & $past(set_i)) == $past(set_i)));

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> ((q_q & ~$past(wdata_i) & ~$past(set_i)) == '0));

  p_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && set_i == '0) |=> (q_q == $past(q_q)));

endmodule

// File: rtl/can_err_code.sv
module can_err_code #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] ev_i,
  input  logic              wr_i,
  input  logic [CODE_W:0]   wdata_i,
  output logic [CODE_W:0]   code_o
);

  logic              mode_q;
  logic              mode_d;
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_d;
  logic [CODE_W-1:0] kept;
  logic              any_ev;
  logic              upd;

  assign any_ev = |ev_i;
  assign upd    = wr_i | any_ev;

  always_comb begin
    kept   = wr_i ? (code_q & wdata_i[CODE_W-1:0]) : code_q;
    mode_d = wr_i ? wdata_i[CODE_W] : mode_q;
    if (any_ev) begin
      code_d = mode_q ? (kept | ev_i) : ev_i;
    end else begin
      code_d = kept;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      code_q <= '0;
    end else if (upd) begin
      mode_q <= mode_d;
      code_q <= code_d;
    end
  end

  assign code_o = {mode_q, code_q};

  p_accum_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !wr_i && ev_i != '0) |=> (code_q == ($past(code_q) | $past(ev_i))));

  p_replace_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && ev_i != '0) |=> (code_q == $past(ev_i)));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && ev_i == '0) |=> (code_q == ($past(code_q) & $past(wdata_i[CODE_W-1:0]))));

endmodule

// File: rtl/can_err_level.sv
module can_err_level
  import can_err_pkg::*;
#(
  parameter int CNT_W    = 9,
  parameter int WARN_LVL = 96,
  parameter int PASS_LVL = 127,
  parameter int OFF_LVL  = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tec_i,
  input  logic [CNT_W-1:0] rec_i,
  output err_level_e       level_o,
  output logic             warn_rise_o,
  output logic             pass_rise_o,
  output logic             off_rise_o
);

  localparam logic [CNT_W-1:0] WARN_C = CNT_W'(WARN_LVL);
  localparam logic [CNT_W-1:0] PASS_C = CNT_W'(PASS_LVL);
  localparam logic [CNT_W-1:0] OFF_C  = CNT_W'(OFF_LVL);

  logic       warn_c;
  logic       pass_c;
  logic       off_c;
  logic [2:0] prev_q;
  logic [2:0] prev_d;
  err_level_e lvl_q;
  err_level_e lvl_d;

  always_comb begin
    warn_c = (tec_i >= WARN_C) || (rec_i >= WARN_C);
    pass_c = (tec_i > PASS_C) || (rec_i > PASS_C);
    off_c  = (tec_i > OFF_C);
    prev_d = {off_c, pass_c, warn_c};
    if (off_c) begin
      lvl_d = LVL_BUSOFF;
    end else if (pass_c) begin
      lvl_d = LVL_PASSIVE;
    end else if (warn_c) begin
      lvl_d = LVL_WARN;
    end else begin
      lvl_d = LVL_ACTIVE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      lvl_q  <= LVL_ACTIVE;
    end else begin
      prev_q <= prev_d;
      lvl_q  <= lvl_d;
    end
  end

  assign warn_rise_o = warn_c & ~prev_q[0];
  assign pass_rise_o = pass_c & ~prev_q[1];
  assign off_rise_o  = off_c  & ~prev_q[2];
  assign level_o     = lvl_q;

  p_warn_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_rise_o && $stable(tec_i) && $stable(rec_i)) |=> !warn_rise_o);

  p_pass_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pass_rise_o |=> (!pass_rise_o || !$stable(rec_i) || !$stable(tec_i)));

  p_off_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    off_rise_o |=> (lvl_q == LVL_BUSOFF));

  p_level_rank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == LVL_ACTIVE) |-> !(prev_q[0]));

endmodule

// File: rtl/can_err_regs.sv
module can_err_regs
  import can_err_pkg::*;
#(
  parameter int CNT_W    = 9,
  parameter int WARN_LVL = 96,
  parameter int PASS_LVL = 127,
  parameter int OFF_LVL  = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             ev_bus_lock,
  input  logic             ev_overload,
  input  logic             ev_overrun,
  input  logic             ev_bo_recover,
  input  logic [6:0]       err_code_ev,
  input  logic [CNT_W-1:0] tx_err_cnt,
  input  logic [CNT_W-1:0] rx_err_cnt,
  output logic [1:0]       err_level,
  output logic             err_irq
);

  localparam logic [CNT_W-1:0] SAT_C = CNT_W'(255);

  logic [FLAG_W-1:0] flag_set;
  logic [FLAG_W-1:0] flag_q;
  logic [FLAG_W-1:0] fen_q;
  logic [FLAG_W-1:0] fen_d;
  logic              ien_q;
  logic              ien_d;
  logic [CODE_W:0]   code_q;
  logic              warn_rise;
  logic              pass_rise;
  logic              off_rise;
  err_level_e        lvl;
  logic              stat_bit;
  logic              wr_flag;
  logic              wr_fen;
  logic              wr_code;
  logic              wr_ien;
  logic [7:0]        tx_rd;
  logic [7:0]        rx_rd;
  logic [7:0]        stat_rd;
  logic [7:0]        ien_rd;

  assign wr_flag = reg_wr && (reg_addr == A_FLAG);
  assign wr_fen  = reg_wr && (reg_addr == A_FEN);
  assign wr_code = reg_wr && (reg_addr == A_CODE);
  assign wr_ien  = reg_wr && (reg_addr == A_IEN);

  can_err_level #(
    .CNT_W   (CNT_W),
    .WARN_LVL(WARN_LVL),
    .PASS_LVL(PASS_LVL),
    .OFF_LVL (OFF_LVL)
  ) u_level (
    .clk        (clk),
    .rst_n      (rst_n),
    .tec_i      (tx_err_cnt),
    .rec_i      (rx_err_cnt),
    .level_o    (lvl),
    .warn_rise_o(warn_rise),
    .pass_rise_o(pass_rise),
    .off_rise_o (off_rise)
  );

  always_comb begin
    flag_set              = '0;
    flag_set[FB_BUSLOCK]  = ev_bus_lock;
    flag_set[FB_OVERLOAD] = ev_overload;
    flag_set[FB_OVERRUN]  = ev_overrun;
    flag_set[FB_BORECOV]  = ev_bo_recover;
    flag_set[FB_BOENTRY]  = off_rise;
    flag_set[FB_PASSIVE]  = pass_rise;
    flag_set[FB_WARN]     = warn_rise;
    flag_set[FB_BUSERR]   = |err_code_ev;
  end

  can_err_flagbank #(.W(FLAG_W)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (flag_set),
    .wr_i   (wr_flag),
    .wdata_i(reg_wdata),
    .q_o    (flag_q)
  );

  can_err_code #(.CODE_W(CODE_W)) u_code (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_i   (err_code_ev),
    .wr_i   (wr_code),
    .wdata_i(reg_wdata),
    .code_o (code_q)
  );

  // Enable registers: next state
  always_comb begin
    fen_d = wr_fen ? reg_wdata : fen_q;
    ien_d = wr_ien ? reg_wdata[IRQ_BIT] : ien_q;
  end

  // Enable registers: storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fen_q <= '0;
      ien_q <= 1'b0;
    end else if (wr_fen || wr_ien) begin
      fen_q <= fen_d;
      ien_q <= ien_d;
    end
  end

  assign stat_bit = |(flag_q & fen_q);
  assign err_irq  = stat_bit & ien_q;
  assign err_level = lvl;

  always_comb begin
    tx_rd            = (tx_err_cnt > SAT_C) ? 8'hFF : tx_err_cnt[7:0];
    rx_rd            = (rx_err_cnt > SAT_C) ? 8'hFF : rx_err_cnt[7:0];
    stat_rd          = '0;
    stat_rd[IRQ_BIT] = stat_bit;
    ien_rd           = '0;
    ien_rd[IRQ_BIT]  = ien_q;
    case (reg_addr)
      A_FLAG:  reg_rdata = flag_q;
      A_FEN:   reg_rdata = fen_q;
      A_CODE:  reg_rdata = code_q;
      A_TXC:   reg_rdata = tx_rd;
      A_RXC:   reg_rdata = rx_rd;
      A_STAT:  reg_rdata = stat_rd;
      A_IEN:   reg_rdata = ien_rd;
      default: reg_rdata = {6'd0, lvl};
    endcase
  end

  p_irq_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ien && !reg_wdata[IRQ_BIT]) |=> !err_irq);

  p_irq_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fen && reg_wdata == 8'h00) |=> !err_irq);

  p_buserr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code_ev != '0) |=> flag_q[FB_BUSERR]);

endmodule

// File: tb/can_err_regs_tb.sv
module can_err_regs_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       ev_bus_lock, ev_overload, ev_overrun, ev_bo_recover;
  logic [6:0] err_code_ev;
  logic [8:0] tx_err_cnt, rx_err_cnt;
  logic [1:0] err_level;
  logic       err_irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  can_err_regs u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .ev_bus_lock  (ev_bus_lock),
    .ev_overload  (ev_overload),
    .ev_overrun   (ev_overrun),
    .ev_bo_recover(ev_bo_recover),
    .err_code_ev  (err_code_ev),
    .tx_err_cnt   (tx_err_cnt),
    .rx_err_cnt   (rx_err_cnt),
    .err_level    (err_level),
    .err_irq      (err_irq)
  );

  // Vector: {events[3:0] (lock,overload,overrun,recover), code[6:0], mode, exp_flags[7:0], exp_code[7:0]}
  localparam int NV = 8;
  localparam logic [27:0] VEC [NV] = '{
    {4'b1000, 7'h00, 1'b0, 8'h80, 8'h00},
    {4'b0100, 7'h00, 1'b0, 8'h40, 8'h00},
    {4'b0010, 7'h00, 1'b0, 8'h20, 8'h00},
    {4'b0001, 7'h00, 1'b0, 8'h10, 8'h00},
    {4'b0000, 7'h01, 1'b1, 8'h01, 8'h81},
    {4'b0000, 7'h40, 1'b0, 8'h01, 8'h40},
    {4'b1111, 7'h7F, 1'b1, 8'hF1, 8'hFF},
    {4'b0000, 7'h00, 1'b0, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    tick();
    reg_wr    = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] ev, input logic [6:0] code);
    {ev_bus_lock, ev_overload, ev_overrun, ev_bo_recover} = ev;
    err_code_ev = code;
    tick();
    {ev_bus_lock, ev_overload, ev_overrun, ev_bo_recover} = 4'b0;
    err_code_ev = '0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0;
    reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    {ev_bus_lock, ev_overload, ev_overrun, ev_bo_recover} = 4'b0;
    err_code_ev = '0; tx_err_cnt = '0; rx_err_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    rd(3'd0, d); check("R10 reset flags", d, 8'h00);
    rd(3'd2, d); check("R10 reset code", d, 8'h00);
    rd(3'd5, d); check("R10 reset status", d, 8'h00);
    check("R10 reset level", {6'd0, err_level}, 8'h00);
    check("R10 reset irq", {7'd0, err_irq}, 8'h00);

    // R1/R4/R5/R6: vector table
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, 8'h00);
      wr(3'd2, {VEC[i][16], 7'h00});
      pulse(VEC[i][27:24], VEC[i][23:17]);
      rd(3'd0, d); check($sformatf("R1 vector %0d flags", i), d, VEC[i][15:8]);
      rd(3'd2, d); check($sformatf("R4 vector %0d code", i), d, VEC[i][7:0]);
    end

    // R2: partial clear keeps bits written 1
    pulse(4'b1111, 7'h01);
    wr(3'd0, 8'h3F);
    rd(3'd0, d); check("R2 partial clear", d, 8'h31);

    // R3: overrun event with clearing write in the same cycle
    reg_addr = 3'd0; reg_wdata = 8'h00; reg_wr = 1'b1; ev_overrun = 1'b1;
    tick();
    reg_wr = 1'b0; ev_overrun = 1'b0;
    rd(3'd0, d); check("R3 event beats clear", d, 8'h20);

    // R5: accumulate mode
    wr(3'd2, 8'h80);
    pulse(4'b0000, 7'h03);
    pulse(4'b0000, 7'h14);
    rd(3'd2, d); check("R5 accumulate", d, 8'h97);
    // R4: clear by writing 0, keep bit 4
    wr(3'd2, 8'h90);
    rd(3'd2, d); check("R4 code clear", d, 8'h90);
    // R6: replace mode
    wr(3'd2, 8'h00);
    pulse(4'b0000, 7'h03);
    pulse(4'b0000, 7'h40);
    rd(3'd2, d); check("R6 replace", d, 8'h40);

    // R7: warning threshold
    wr(3'd0, 8'h00);
    tx_err_cnt = 9'd95; tick();
    rd(3'd0, d); check("R7 below warning", d, 8'h00);
    tx_err_cnt = 9'd96; tick();
    rd(3'd0, d); check("R7 warning flag", d, 8'h02);
    check("R10 warning level", {6'd0, err_level}, 8'h01);
    wr(3'd0, 8'h00);
    tx_err_cnt = 9'd100; tick();
    rd(3'd0, d); check("R7 no re-set", d, 8'h00);

    // R8: passive
    tx_err_cnt = 9'd127; tick();
    rd(3'd0, d); check("R8 at 127 not passive", d, 8'h00);
    tx_err_cnt = 9'd128; tick();
    rd(3'd0, d); check("R8 passive flag", d, 8'h04);
    check("R10 passive level", {6'd0, err_level}, 8'h02);

    // R9: bus-off
    tx_err_cnt = 9'd256; tick();
    rd(3'd0, d); check("R9 bus-off flag", d, 8'h0C);
    check("R10 bus-off level", {6'd0, err_level}, 8'h03);
    rd(3'd7, d); check("R10 level register", d, 8'h03);
    rd(3'd3, d); check("R12 tx count saturated", d, 8'hFF);
    rx_err_cnt = 9'd77; #1;
    rd(3'd4, d); check("R12 rx count", d, 8'h4D);

    // R11: status and interrupt gating
    rd(3'd5, d); check("R11 status masked", d, 8'h00);
    wr(3'd1, 8'h08);
    rd(3'd5, d); check("R11 status enabled", d, 8'h20);
    check("R11 irq gated off", {7'd0, err_irq}, 8'h00);
    wr(3'd6, 8'h20);
    check("R11 irq on", {7'd0, err_irq}, 8'h01);
    wr(3'd0, 8'h00);
    check("R11 irq after clear", {7'd0, err_irq}, 8'h00);

    // R10: recovery to active, then receive count jumps past two thresholds
    tx_err_cnt = 9'd0; rx_err_cnt = 9'd0; tick();
    check("R10 back to active", {6'd0, err_level}, 8'h00);
    wr(3'd0, 8'h00);
    rx_err_cnt = 9'd130; tick();
    rd(3'd0, d); check("R8 warning and passive together", d, 8'h06);
    check("R10 passive from rx", {6'd0, err_level}, 8'h02);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule